// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits at the head of a receive path and decides, from the first six bytes of an incoming frame (the destination address), whether the frame is kept or discarded. Bytes arrive one per cycle on a byte stream with a valid qualifier. A start strobe marks the first byte of each frame. A small register port holds the filter configuration: a receive enable, a promiscuous bit, a hash enable, a 48-bit station address held as three 16-bit words, and a 64-bit multicast hash table held as four 16-bit words.

Once the sixth address byte has been consumed, the block issues a one-cycle decision. The decision carries an accept bit and a code naming the rule that accepted the frame. Rules are tried in priority order: receive disabled, promiscuous, station match, broadcast, hash. The hash index is the top six bits of a CRC-32 run over the six address bytes. That CRC uses the reflected polynomial, starts from all ones, takes each byte least-significant bit first, and is not inverted at the end. The configuration is copied into an active set when a frame starts, so register writes made during a frame apply from the next frame.

A four-state machine controls the flow. IDLE waits after reset. COLLECT shifts in address bytes. DECIDE presents the decision for one cycle. DONE ignores the remainder of the frame. The transitions are as follows:
- start-with-byte goes from any state to COLLECT.
- sixth-byte goes from COLLECT to DECIDE.
- decision-shown goes from DECIDE to DONE.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` is low. All configuration registers reset to zero, so receive starts disabled.
- R2: When the enable bit of the active configuration (bit 0 of register 0) is clear, every frame is rejected with rule code 0 (none).
- R3: When enabled with the promiscuous bit (bit 6 of register 0) set, every frame is accepted with rule code 4, whatever its address.
- R4: A destination equal to the station address is accepted with rule code 1. Register 1 holds destination bytes 0 and 1, register 2 holds bytes 2 and 3, and register 3 holds bytes 4 and 5. In each register the earlier byte is in bits 15:8.
- R5: A destination of six 0xFF bytes that does not equal the station address is accepted with rule code 2. A station address of all ones takes rule 1 first.
- R6: A frame that fails the station and broadcast checks is rejected with rule code 0 when the hash enable bit (bit 11 of register 0) is clear.
- R7: With hash enabled, the index is CRC bits 31:26, where the CRC is computed as described above over the six address bytes. Index bits 5:4 select hash register 4 + index[5:4], and index bits 3:0 select the bit within it. A set bit accepts the frame with rule code 3; a clear bit rejects it with rule code 0.
- R8: `dec_valid` rises in the cycle after the edge that consumes the sixth address byte and stays high for exactly one cycle. Idle cycles between address bytes are allowed. Bytes after the sixth produce no further decision.
- R9: The configuration is captured on the start byte of each frame. A register write made later in the same frame changes only the decision of the next frame.
- R10: A start strobe arriving before the sixth byte of the current frame abandons that frame. No decision is issued for the abandoned frame; the address is collected afresh from the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 config, 1-3 station words, 4-7 hash words |
| cfg_wdata | input | 16 | Register write data |
| frm_start | input | 1 | Marks the first byte of a frame; qualified by `byte_valid` |
| byte_valid | input | 1 | Byte stream qualifier |
| byte_data | input | 8 | Byte stream data |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted, valid with `dec_valid` |
| dec_rule | output | 3 | Rule code: 0 none, 1 station, 2 broadcast, 3 hash, 4 promiscuous |

## Verification
The decision is due one cycle after the sixth address byte is presented. The bench drives that byte at a falling edge, the rising edge then loads the CRC and moves the state machine to DECIDE, and the bench samples the decision at the next falling edge. It samples again one falling edge later and expects `dec_valid` low, which checks the single-cycle pulse. The same two sampling points hold when idle cycles are inserted between bytes, when extra bytes trail the address, and when a register write lands inside a frame. The bench recomputes the CRC, the hash bit and the rule priority from its own mirror of the registers.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    typedef enum logic [2:0] {
        RULE_NONE    = 3'd0,
        RULE_STATION = 3'd1,
        RULE_BCAST   = 3'd2,
        RULE_HASH    = 3'd3,
        RULE_PROMISC = 3'd4
    } rule_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2,
        ST_DONE    = 2'd3
    } fstate_e;

    // One byte through a reflected CRC-32, least-significant bit first.
    function automatic logic [31:0] crc8_step(input logic [31:0] c_in,
                                              input logic [7:0]  b,
                                              input logic [31:0] poly);
        logic [31:0] c;
        c = c_in;
        for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[k]) c = (c >> 1) ^ poly;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxaf_cfg_regs.sv
module rxaf_cfg_regs #(
    parameter int WORD_W     = 16,
    parameter int STA_WORDS  = 3,
    parameter int HASH_WORDS = 4,
    parameter int AW         = 3,
    parameter int EN_BIT     = 0,
    parameter int PROM_BIT   = 6,
    parameter int HEN_BIT    = 11,
    localparam int STA_W     = STA_WORDS * WORD_W,
    localparam int HASH_W    = HASH_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              latch,
    output logic              act_en,
    output logic              act_prom,
    output logic              act_hen,
    output logic [STA_W-1:0]  act_station,
    output logic [HASH_W-1:0] act_hash
);
    localparam int STA_BASE  = 1;
    localparam int HASH_BASE = STA_BASE + STA_WORDS;

    logic              en_q, prom_q, hen_q;
    logic [STA_W-1:0]  sta_q;
    logic [HASH_W-1:0] hash_q;

    // Live register file; station word 0 lands in the top bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            prom_q <= 1'b0;
            hen_q  <= 1'b0;
            sta_q  <= '0;
            hash_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(0)) begin
                en_q   <= wr_data[EN_BIT];
                prom_q <= wr_data[PROM_BIT];
                hen_q  <= wr_data[HEN_BIT];
            end
            for (int i = 0; i < STA_WORDS; i++) begin
                if (wr_addr == AW'(STA_BASE + i))
                    sta_q[(STA_WORDS-1-i)*WORD_W +: WORD_W] <= wr_data;
            end
            for (int i = 0; i < HASH_WORDS; i++) begin
                if (wr_addr == AW'(HASH_BASE + i))
                    hash_q[i*WORD_W +: WORD_W] <= wr_data;
            end
        end
    end

    // Active copy, captured at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en      <= 1'b0;
            act_prom    <= 1'b0;
            act_hen     <= 1'b0;
            act_station <= '0;
            act_hash    <= '0;
        end else if (latch) begin
            act_en      <= en_q;
            act_prom    <= prom_q;
            act_hen     <= hen_q;
            act_station <= sta_q;
            act_hash    <= hash_q;
        end
    end

    p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> ($stable(act_station) && $stable(act_hash) &&
                    $stable({act_en, act_prom, act_hen})));

endmodule

// File: rtl/rxaf_crc.sv
module rxaf_crc #(
    parameter logic [31:0] POLY  = 32'hEDB88320,
    parameter int          IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             upd,
    input  logic [7:0]       din,
    output logic [IDX_W-1:0] idx
);
    import rxaf_pkg::*;

    localparam logic [31:0] SEED = '1;

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= SEED;
        else if (upd)   crc_q <= crc8_step(init ? SEED : crc_q, din, POLY);
        else if (init)  crc_q <= SEED;
    end

    assign idx = crc_q[31 -: IDX_W];

    p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(init || upd) |=> $stable(crc_q));

endmodule

// File: rtl/rxaf_matcher.sv
module rxaf_matcher #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 6,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int HASH_BITS = 1 << IDX_W,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_start,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    input  logic                 act_en,
    input  logic                 act_prom,
    input  logic                 act_hen,
    input  logic [ADDR_W-1:0]    act_station,
    input  logic [HASH_BITS-1:0] act_hash,
    input  logic [IDX_W-1:0]     crc_idx,
    output logic                 snap,
    output logic                 crc_init,
    output logic                 crc_upd,
    output logic                 dec_valid,
    output logic                 dec_accept,
    output rxaf_pkg::rule_e      dec_rule
);
    import rxaf_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

    fstate_e           state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    logic              first, in_addr, take;
    logic              sta_hit, bc_hit, hash_hit;
    rule_e             rule;

    assign first   = frm_start && byte_valid;
    assign in_addr = (state == ST_COLLECT) && byte_valid && !frm_start;
    assign take    = first || in_addr;

    assign snap     = first;
    assign crc_init = first;
    assign crc_upd  = take;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (first) begin
            nxt = ST_COLLECT;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_COLLECT: if (byte_valid && cnt == LAST) nxt = ST_DECIDE;
                ST_DECIDE:  nxt = ST_DONE;
                ST_DONE:    nxt = ST_DONE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // Byte counter and address shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            addr_q <= '0;
        end else begin
            if (first)        cnt <= CNT_W'(1);
            else if (in_addr) cnt <= cnt + CNT_W'(1);
            if (take)         addr_q <= {addr_q[ADDR_W-9:0], byte_data};
        end
    end

    assign sta_hit  = (addr_q == act_station);
    assign bc_hit   = &addr_q;
    assign hash_hit = act_hash[crc_idx];

    // Outputs
    always_comb begin
        rule = RULE_NONE;
        if (state == ST_DECIDE && act_en) begin
            if (act_prom)                 rule = RULE_PROMISC;
            else if (sta_hit)             rule = RULE_STATION;
            else if (bc_hit)              rule = RULE_BCAST;
            else if (act_hen && hash_hit) rule = RULE_HASH;
            else                          rule = RULE_NONE;
        end
        dec_valid  = (state == ST_DECIDE);
        dec_accept = dec_valid && (rule != RULE_NONE);
        dec_rule   = rule;
    end

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(ADDR_BYTES));
    p_off_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !act_en) |-> (!dec_accept && dec_rule == RULE_NONE));
    p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && act_en && act_prom) |-> (dec_accept && dec_rule == RULE_PROMISC));
    p_rule_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (dec_rule == RULE_NONE && !dec_accept));
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        first |=> (state == ST_COLLECT && !dec_valid));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
    parameter int          ADDR_BYTES = 6,
    parameter int          WORD_W     = 16,
    parameter int          IDX_W      = 6,
    parameter logic [31:0] CRC_POLY   = 32'hEDB88320,
    localparam int         STA_WORDS  = (8 * ADDR_BYTES) / WORD_W,
    localparam int         HASH_WORDS = (1 << IDX_W) / WORD_W,
    localparam int         AW         = $clog2(1 + STA_WORDS + HASH_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              frm_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [2:0]        dec_rule
);
    import rxaf_pkg::*;

    logic                         snap, crc_init, crc_upd;
    logic                         act_en, act_prom, act_hen;
    logic [STA_WORDS*WORD_W-1:0]  act_station;
    logic [HASH_WORDS*WORD_W-1:0] act_hash;
    logic [IDX_W-1:0]             crc_idx;
    rule_e                        rule;

    rxaf_cfg_regs #(
        .WORD_W(WORD_W), .STA_WORDS(STA_WORDS), .HASH_WORDS(HASH_WORDS), .AW(AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .latch(snap), .act_en(act_en), .act_prom(act_prom),
        .act_hen(act_hen), .act_station(act_station), .act_hash(act_hash)
    );

    rxaf_crc #(.POLY(CRC_POLY), .IDX_W(IDX_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
        .din(byte_data), .idx(crc_idx)
    );

    rxaf_matcher #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_match (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .act_en(act_en), .act_prom(act_prom),
        .act_hen(act_hen), .act_station(act_station), .act_hash(act_hash),
        .crc_idx(crc_idx), .snap(snap), .crc_init(crc_init), .crc_upd(crc_upd),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_rule(rule)
    );

    assign dec_rule = rule;

endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        frm_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_rule;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;

    logic [15:0] m_cfg;
    logic [47:0] m_sta;
    logic [63:0] m_hash;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frm_start(frm_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_rule(dec_rule)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = a[47-8*i -: 8];
            for (int k = 0; k < 8; k++)
                c = ((c[0] ^ b[k]) != 0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c[31:26];
    endfunction

    // Expected rule code from the register mirror
    function automatic logic [2:0] model(input logic [47:0] a);
        if (!m_cfg[0])           return 3'd0;
        if (m_cfg[6])            return 3'd4;
        if (a == m_sta)          return 3'd1;
        if (a == 48'hFFFF_FFFF_FFFF) return 3'd2;
        if (m_cfg[11] && m_hash[hash_idx(a)]) return 3'd3;
        return 3'd0;
    endfunction

    task automatic wr(input logic [2:0] ad, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ad == 3'd0) m_cfg = d;
        else if (ad <= 3'd3) m_sta[(3-ad)*16 +: 16] = d;
        else m_hash[(ad-4)*16 +: 16] = d;
    endtask

    task automatic send(input logic [47:0] a, input bit gap, input bit midwr, input string req);
        logic [2:0] er = model(a);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            frm_start = (i == 0); byte_valid = 1'b1; byte_data = a[47-8*i -: 8];
            cfg_we = midwr && (i == 2); cfg_addr = 3'd0; cfg_wdata = 16'h0000;
            if (gap && i < 5) begin
                @(negedge clk);
                frm_start = 1'b0; byte_valid = 1'b0; cfg_we = 1'b0;
                check({req, " R8 no early decision"}, {31'b0, dec_valid}, 32'd0);
            end
        end
        @(negedge clk);
        frm_start = 1'b0; byte_valid = 1'b0; cfg_we = 1'b0;
        if (midwr) m_cfg = 16'h0000;
        check({req, " R8 valid"}, {31'b0, dec_valid}, 32'd1);
        check({req, " rule"}, {29'b0, dec_rule}, {29'b0, er});
        check({req, " accept"}, {31'b0, dec_accept}, {31'b0, (er != 3'd0)});
        @(negedge clk);
        check({req, " R8 one-cycle"}, {31'b0, dec_valid}, 32'd0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] sta, uni, mc, bc;
        logic [47:0] kinds [4];
        m_cfg = '0; m_sta = '0; m_hash = '0;
        sta = 48'h0211_2233_4455;
        uni = 48'h02AA_BBCC_DDEE;
        mc  = 48'h0100_5E00_0017;
        bc  = 48'hFFFF_FFFF_FFFF;
        kinds[0] = sta; kinds[1] = bc; kinds[2] = mc; kinds[3] = uni;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset valid", {31'b0, dec_valid}, 32'd0);
        // R1: registers start at zero, so a frame is rejected
        send(bc, 0, 0, "R1 reset config");

        wr(3'd1, 16'h0211); wr(3'd2, 16'h2233); wr(3'd3, 16'h4455);
        wr(3'd4, 16'hA5A5); wr(3'd5, 16'h5A5A); wr(3'd6, 16'hFFFF); wr(3'd7, 16'h0000);

        // R2 R3 R4 R5 R6 R7: all enable/promiscuous/hash combos by address class
        for (int c = 0; c < 8; c++) begin
            wr(3'd0, {4'b0, c[2], 4'b0, c[1], 5'b0, c[0]});
            for (int k = 0; k < 4; k++)
                send(kinds[k], 0, 0, "R2 R3 R4 R5 R6 config sweep");
        end

        // R7: every hash index, set bit accepts, clear bit rejects
        wr(3'd0, 16'h0801);
        for (int k = 0; k < 64; k++) begin
            logic [47:0] a = {40'h0100_5E00_00, 8'(k)};
            logic [5:0]  ix = hash_idx(a);
            for (int w = 0; w < 4; w++)
                wr(3'(4 + w), (ix[5:4] == 2'(w)) ? (16'h1 << ix[3:0]) : 16'h0);
            send(a, 0, 0, "R7 hash bit set");
            for (int w = 0; w < 4; w++)
                wr(3'(4 + w), (ix[5:4] == 2'(w)) ? ~(16'h1 << ix[3:0]) : 16'hFFFF);
            send(a, 0, 0, "R7 hash bit clear");
        end

        // R5: all-ones station takes station rule first
        wr(3'd1, 16'hFFFF); wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF);
        send(bc, 0, 0, "R5 station precedes broadcast");
        wr(3'd1, 16'h0211); wr(3'd2, 16'h2233); wr(3'd3, 16'h4455);

        // R8: idle gaps between address bytes
        send(sta, 1, 0, "R8 gapped station");
        send(uni, 1, 0, "R8 gapped unicast");
        // R8: trailing bytes give no second decision
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_data = 8'hFF;
            check("R8 trailing bytes ignored", {31'b0, dec_valid}, 32'd0);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        check("R8 trailing bytes ignored", {31'b0, dec_valid}, 32'd0);

        // R9: disable written mid-frame; this frame still accepted, next rejected
        send(sta, 0, 1, "R9 mid-frame write");
        send(sta, 0, 0, "R9 next frame");
        wr(3'd0, 16'h0001);

        // R10: abandoned partial frame then a fresh one
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            frm_start = (i == 0); byte_valid = 1'b1; byte_data = 8'hFF;
        end
        @(negedge clk);
        frm_start = 1'b0; byte_valid = 1'b0;
        check("R10 no decision on partial", {31'b0, dec_valid}, 32'd0);
        send(sta, 0, 0, "R10 restart station");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            frm_start = (i == 0); byte_valid = 1'b1; byte_data = 8'hFF;
        end
        send(uni, 0, 0, "R10 restart unicast");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule